// File: doc/BRIEF.md
# Exponent-Driven Sample Aligner

This block restores the dynamic range of a signed mixer sample after an external variable-gain amplifier has compressed it. Each 15-bit sample is sign-extended to 22 bits and shifted toward the top of the word by a 3-bit gain exponent. Each exponent step is worth 6 dB, which is one bit position. The shift is arithmetic: bits vacated at the bottom are zero and the top positions carry copies of the sign.

The exponent that sets the amplifier gain reaches the digital samples only after the amplifier interface and the converter have added their delay. The block therefore passes the raw exponent through a shift register of configurable depth before it uses the exponent. An inhibit input bypasses the exponent and forces unity alignment, with the sample's sign bit landing in the top output bit. The result is registered, and its valid flag follows the input flag one cycle later.

Top module: `exp_align`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0 and `out_word` is 0. Every stage of the exponent delay line resets to code 3'b111.
- R2: With applied code c (0..7), `out_word` equals the 15-bit sample sign-extended to 22 bits and multiplied by 2^c. Output bit 21 always equals input bit 14, and no code overflows the word.
- R3: At code 3'b000 the input LSB lands in output bit 0, and output bits 21..15 are all copies of input bit 14.
- R4: At code 3'b111 input bit 14 lands in output bit 21 and output bits 6..0 are zero. Each lower code moves the sample down by one bit and adds one more sign copy at the top.
- R5: The code applied to the sample accepted on a given cycle is the `exp_raw` value from `EXP_DELAY` cycles earlier, where `EXP_DELAY` is 0..15. Until the line has filled after reset, the applied code is 3'b111.
- R6: While `exp_inhibit` is 1, the applied code is 3'b111 on that same cycle, whatever the delayed exponent is.
- R7: `out_valid` equals `in_valid` from the previous cycle, and a sample accepted on a cycle appears on `out_word` one cycle later.
- R8: While `in_valid` is 0, `out_word` keeps its previous value. Changes on `in_sample` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample valid |
| in_sample | input | 15 | Signed mixer sample |
| exp_raw | input | 3 | Gain exponent, 3'b111 = 0 dB, 3'b000 = -42 dB |
| exp_inhibit | input | 1 | Forces the applied code to 3'b111 |
| out_valid | output | 1 | Output valid |
| out_word | output | 22 | Aligned signed sample |

## Verification
A delay line that is off by one stage shows up as a wrong power of two on the first sample after each exponent change. It also shows up on the samples right after reset, which must use code 3'b111 for exactly `EXP_DELAY` cycles. A faulty shifter or fill appears in the very next output word, as low bits that are not zero or as top bits that do not match the sign. A broken hold or valid register shows one cycle later, either as a changed word while `in_valid` is low or as a flag that is misaligned with the data.

// File: rtl/exp_align_pkg.sv
package exp_align_pkg;
    localparam int IN_W    = 15;
    localparam int OUT_W   = 22;
    localparam int CODE_W  = 3;
    localparam int GROW_W  = OUT_W - IN_W;
    localparam int MAX_DLY = 15;

    typedef logic [IN_W-1:0]   sample_t;
    typedef logic [OUT_W-1:0]  word_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t UNITY_CODE = '1;

    typedef struct packed {
        logic  valid;
        word_t data;
    } beat_t;

    function automatic word_t sign_extend(input sample_t s);
        return {{GROW_W{s[IN_W-1]}}, s};
    endfunction
endpackage

// File: rtl/exp_delay_line.sv
module exp_delay_line
    import exp_align_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t code_in,
    output code_t code_out
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign code_out = code_in;
        end else begin : g_line
            code_t stage [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stage[i] <= UNITY_CODE;
                end else begin
                    stage[0] <= code_in;
                    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
                end
            end
            assign code_out = stage[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/exp_code_select.sv
module exp_code_select
    import exp_align_pkg::*;
(
    input  code_t delayed_code,
    input  logic  inhibit,
    output code_t applied_code
);
    always_comb begin
        applied_code = inhibit ? UNITY_CODE : delayed_code;
    end
endmodule

// File: rtl/exp_shifter.sv
module exp_shifter
    import exp_align_pkg::*;
(
    input  sample_t sample,
    input  code_t   code,
    output word_t   aligned
);
    localparam int N_CODES = 1 << CODE_W;
    word_t ext;
    word_t cand [N_CODES];

    assign ext = sign_extend(sample);

    generate
        for (genvar c = 0; c < N_CODES; c++) begin : g_pos
            assign cand[c] = ext << c;
        end
    endgenerate

    always_comb begin
        aligned = cand[code];
    end
endmodule

// File: rtl/exp_align.sv
module exp_align
    import exp_align_pkg::*;
#(
    parameter int EXP_DELAY = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [IN_W-1:0]       in_sample,
    input  logic [CODE_W-1:0]     exp_raw,
    input  logic                  exp_inhibit,
    output logic                  out_valid,
    output logic [OUT_W-1:0]      out_word
);
    initial begin
        if (EXP_DELAY < 0 || EXP_DELAY > MAX_DLY)
            $error("EXP_DELAY out of range");
    end

    code_t dly_code;
    code_t eff_code;
    word_t shifted;
    beat_t beat_q;

    exp_delay_line #(.DEPTH(EXP_DELAY)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .code_in  (exp_raw),
        .code_out (dly_code)
    );

    exp_code_select u_sel (
        .delayed_code (dly_code),
        .inhibit      (exp_inhibit),
        .applied_code (eff_code)
    );

    exp_shifter u_shf (
        .sample  (in_sample),
        .code    (eff_code),
        .aligned (shifted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= in_valid;
            if (in_valid) beat_q.data <= shifted;
        end
    end

    assign out_valid = beat_q.valid;
    assign out_word  = beat_q.data;
endmodule

// File: rtl/exp_align_chk.sv
module exp_align_chk
    import exp_align_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    in_valid,
    input sample_t in_sample,
    input logic    exp_inhibit,
    input code_t   eff_code,
    input logic    out_valid,
    input word_t   out_word
);
    assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));

    assert_sign_top_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_word[OUT_W-1] == $past(in_sample[IN_W-1]));

    assert_inhibit_unity_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && exp_inhibit |=>
            out_word[GROW_W-1:0] == '0 && out_word[OUT_W-1:GROW_W] == $past(in_sample));

    assert_inhibit_code_R6: assert property (@(posedge clk) disable iff (rst)
        exp_inhibit |-> eff_code == UNITY_CODE);

    assert_code_zero_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && eff_code == '0 |=>
            out_word == {{GROW_W{$past(in_sample[IN_W-1])}}, $past(in_sample)});
endmodule

bind exp_align exp_align_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sample   (in_sample),
    .exp_inhibit (exp_inhibit),
    .eff_code    (eff_code),
    .out_valid   (out_valid),
    .out_word    (out_word)
);

// File: tb/sim_exp_align.sv
module sim_exp_align;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 2;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [14:0] in_sample;
    logic [2:0]  exp_raw;
    logic        exp_inhibit;
    logic        out_valid;
    logic [21:0] out_word;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exp_align #(.EXP_DELAY(DLY)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .exp_raw(exp_raw), .exp_inhibit(exp_inhibit),
        .out_valid(out_valid), .out_word(out_word)
    );

    // {sample, code, inhibit, expected}
    localparam logic [40:0] VEC [NV] = '{
        {15'h0001, 3'd7, 1'b0, 22'h000080},   // R4
        {15'h0001, 3'd0, 1'b0, 22'h000001},   // R3
        {15'h7FFF, 3'd7, 1'b0, 22'h3FFF80},   // R4
        {15'h4000, 3'd0, 1'b0, 22'h3FC000},   // R3
        {15'h4000, 3'd3, 1'b0, 22'h3E0000},   // R2
        {15'h7FFF, 3'd5, 1'b0, 22'h3FFFE0},   // R2
        {15'h0123, 3'd4, 1'b0, 22'h001230},   // R2
        {15'h0001, 3'd0, 1'b1, 22'h000080},   // R6
        {15'h4000, 3'd2, 1'b1, 22'h200000},   // R6
        {15'h3FFF, 3'd1, 1'b0, 22'h007FFE}    // R4
    };

    task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_sample = 15'h1234; exp_raw = 3'd3; exp_inhibit = 1'b0;
        @(negedge clk);
        tick();
        // R1: reset state
        check("R1 valid", {21'd0, out_valid}, 22'd0);
        check("R1 word", out_word, 22'd0);
        rst = 1'b0; in_valid = 1'b0;
        tick();
        check("R1 first cycle valid", {21'd0, out_valid}, 22'd0);

        // Table walk: R2 R3 R4 R6 R7
        for (int k = 0; k < NV; k++) begin
            exp_raw = VEC[k][25:23];
            exp_inhibit = VEC[k][22];
            in_valid = 1'b0;
            for (int w = 0; w < DLY + 2; w++) tick();
            in_sample = VEC[k][40:26];
            in_valid = 1'b1;
            tick();
            in_valid = 1'b0;
            check($sformatf("R2 vector %0d", k), out_word, VEC[k][21:0]);
            check("R7 valid", {21'd0, out_valid}, 22'd1);
            tick();
            check("R7 valid drop", {21'd0, out_valid}, 22'd0);
        end
        exp_inhibit = 1'b0;

        // R8: hold while idle
        in_valid = 1'b0;
        in_sample = 15'h2AAA;
        tick();
        in_sample = 15'h5555;
        tick();
        check("R8 hold", out_word, VEC[NV-1][21:0]);

        // R5: delay alignment after fresh reset
        rst = 1'b1;
        tick();
        rst = 1'b0;
        for (int i = 0; i < 12; i++) begin
            exp_raw = 3'(i % 8);
            in_sample = 15'h0001;
            in_valid = 1'b1;
            tick();
            if (i < DLY)
                check($sformatf("R5 fill %0d", i), out_word, 22'h000080);
            else
                check($sformatf("R5 delayed %0d", i), out_word, 22'd1 << ((i - DLY) % 8));
        end
        in_valid = 1'b0;

        // R6: inhibit applies without delay
        exp_raw = 3'd0;
        for (int w = 0; w < DLY + 2; w++) tick();
        exp_inhibit = 1'b1;
        in_sample = 15'h0002;
        in_valid = 1'b1;
        tick();
        check("R6 immediate", out_word, 22'h000100);
        exp_inhibit = 1'b0;
        tick();
        check("R6 release", out_word, 22'h000002);
        in_valid = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule